// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital sequencer that sits beside a successive-approximation converter. A small register port holds the analog channel choice, the conversion settings and a completion flag. The sequencer counts conversion cycles on an ADC clock enable. It pulses a sample-and-hold strobe at a fixed point in the conversion, and on the last cycle it captures the digital result that the converter core presents. It then sets the completion flag, which drives a wake-up interrupt when the interrupt is enabled.

A conversion can be started in three ways. Software can set a start bit. In free-running mode a new conversion starts back to back. Software can also arm a low-noise path, so that a conversion begins on its own when the CPU signals that it has halted into idle. In that case the completion interrupt is what brings the CPU back. The channel seen by the analog mux is held fixed while a conversion is in progress, so a new channel choice only reaches the mux at completion.

Register map (`regAddr`): 0 is the channel register. 1 is the control register: bit0 enable, bit1 start (it reads as 1 while converting), bit2 free-run, bit3 interrupt enable, bit4 completion flag, bit5 extended mode. 2 holds the result bits 7:0. 3 holds the result bits above 7, zero-extended.

Top module: `adcSeqTop`

## Requirements
- R1: After reset, every register reads zero, `chanSel` is 0, no conversion is running, and `sampleStrobe` and `irqOut` are low.
- R2: Writing address 0 stores bits 2:0 as the channel code. Code 0 through 7 selects input 0 through 7 on `chanSel`. Bits 7:3 of address 0 always read zero.
- R3: A channel write made during a conversion leaves `chanSel` unchanged until the completion cycle. From the cycle after completion, `chanSel` shows the latest written code. When no conversion is running, a write reaches `chanSel` on the next cycle.
- R4: Writing address 1 with bit0=1 and bit1=1 while no conversion is running starts one. Bit1 reads 1 from the next cycle until completion. A start write made while busy does not restart the count.
- R5: `sampleStrobe` is high for exactly one clock: the cycle of the 14th `adcTick` of a conversion.
- R6: A conversion ends on its 26th `adcTick` in normal mode, or its 25th with bit5=1. The mode is taken when the conversion starts. On that tick the flag (bit4) is set and `resultIn` is captured, readable at addresses 2 and 3 from the next cycle.
- R7: Writing address 1 with bit4=1 clears the flag, and writing bit4=0 leaves it unchanged. A completion in the same cycle as a clear leaves the flag set.
- R8: `irqOut` is high exactly when the flag and the interrupt enable (bit3) are both set.
- R9: When enable=1, interrupt enable=1, free-run=0 and no conversion is running, a pulse on `idleEntry` starts a conversion without any start bit.
- R10: An `idleEntry` pulse has no effect while busy, when disabled, with free-run set or with the interrupt enable clear. A conversion already running continues to completion.
- R11: With free-run set (bit2=1), each completion starts the next conversion at once. Its ticks are counted from the cycle after completion.
- R12: Clearing enable aborts a running conversion. No further strobe or flag comes from it, and bit1 reads 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` (combinational) |
| idleEntry | input | 1 | One-cycle pulse: the CPU has halted into idle |
| adcTick | input | 1 | ADC clock enable, one pulse per ADC cycle |
| resultIn | input | 10 | Conversion result from the converter core |
| chanSel | output | 3 | Channel select to the analog mux |
| sampleStrobe | output | 1 | Sample-and-hold instant |
| irqOut | output | 1 | Completion interrupt / wake-up |

## Verification
The bench builds the block with its defaults: a 3-bit channel, a 10-bit result, the strobe on tick 14, and conversions of 26 or 25 ticks. Because the result is wider than one byte, both result read addresses carry data, so the split read path is exercised. The short default lengths let a full conversion run under three tick patterns (every cycle, every third cycle and pseudo-random) and still leave room for free-running chains, aborts and idle starts within a short run. A behavioural model in the bench tracks the tick count independently and compares every output and the read data on every clock.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  // control-register bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_GO   = 1;
  localparam int BIT_FREE = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_FLAG = 4;
  localparam int BIT_EXT  = 5;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic busy;
    logic sampleTick;
    logic doneTick;
  } seqStrobes_t;

  // settings from the register datapath to the sequencer
  typedef struct packed {
    logic enable;
    logic freeRun;
    logic irqEn;
    logic extMode;   // mode that a conversion starting this cycle uses
  } seqCfg_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int SAMPLE_TICK = 14,
  parameter int LEN_NORMAL  = 26,
  parameter int LEN_EXT     = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        adcTick,
  input  logic        idleEntry,
  input  logic        swStartReq,
  input  seqCfg_t     cfg,
  output seqStrobes_t strb
);

  localparam int LEN_MAX = (LEN_NORMAL > LEN_EXT) ? LEN_NORMAL : LEN_EXT;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);
  localparam logic [CNT_W-1:0] SAMPLE_IDX = CNT_W'(SAMPLE_TICK - 1);
  localparam logic [CNT_W-1:0] LAST_NORM  = CNT_W'(LEN_NORMAL - 1);
  localparam logic [CNT_W-1:0] LAST_EXT   = CNT_W'(LEN_EXT - 1);

  logic             busy;
  logic             convExt;
  logic [CNT_W-1:0] tickCnt;
  logic             idleArmed;
  logic             startConv;
  logic             liveTick;
  logic             doneTick;

  assign idleArmed = cfg.enable && cfg.irqEn && !cfg.freeRun;
  assign startConv = !busy && (swStartReq || (idleEntry && idleArmed));
  assign liveTick  = busy && cfg.enable && adcTick;
  assign doneTick  = liveTick && (tickCnt == (convExt ? LAST_EXT : LAST_NORM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      convExt <= 1'b0;
      tickCnt <= '0;
    end else if (startConv) begin
      busy    <= 1'b1;
      convExt <= cfg.extMode;
      tickCnt <= '0;
    end else if (!cfg.enable) begin
      busy    <= 1'b0;
      tickCnt <= '0;
    end else if (doneTick) begin
      busy    <= cfg.freeRun;
      convExt <= cfg.extMode;
      tickCnt <= '0;
    end else if (busy && adcTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign strb.busy       = busy;
  assign strb.sampleTick = liveTick && (tickCnt == SAMPLE_IDX);
  assign strb.doneTick   = doneTick;

  // R9: an armed idle entry always launches a conversion
  p_idle_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (idleEntry && idleArmed && !busy) |=> busy);

  // R6: a single-shot conversion goes idle after its last tick
  p_single_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneTick && !cfg.freeRun) |=> !busy);

  // R11: free-running keeps the sequencer busy across completions
  p_free_chain_r11: assert property (@(posedge clk) disable iff (!rstN)
    (doneTick && cfg.freeRun) |=> busy);

  // R12: dropping enable ends a conversion
  p_abort_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfg.enable) |=> !busy);

endmodule

// File: rtl/adcSeqRegs.sv
module adcSeqRegs
  import adcSeqPkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [RES_W-1:0] resultIn,
  input  seqStrobes_t      strb,
  output seqCfg_t          cfg,
  output logic             swStartReq,
  output logic [CH_W-1:0]  chanSel,
  output logic             sampleStrobe,
  output logic             irqOut
);

  localparam logic [1:0] A_CHAN = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_RESL = 2'd2;

  logic [CH_W-1:0]  chanReg;
  logic [CH_W-1:0]  chanActive;
  logic [CH_W-1:0]  chanNext;
  logic             enable, freeRun, irqEn, extMode, doneFlag;
  logic [RES_W-1:0] resultReg;
  logic             wrChan, wrCtrl;
  logic [REG_W-1:0] ctrlView;
  logic [1:0]       unusedWrBits;

  assign unusedWrBits = regWrData[REG_W-1:REG_W-2];

  assign wrChan   = regWrEn && (regAddr == A_CHAN);
  assign wrCtrl   = regWrEn && (regAddr == A_CTRL);
  assign chanNext = wrChan ? regWrData[CH_W-1:0] : chanReg;

  assign swStartReq = wrCtrl && regWrData[BIT_EN] && regWrData[BIT_GO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg    <= '0;
      chanActive <= '0;
      enable     <= 1'b0;
      freeRun    <= 1'b0;
      irqEn      <= 1'b0;
      extMode    <= 1'b0;
      doneFlag   <= 1'b0;
      resultReg  <= '0;
    end else begin
      if (wrChan) chanReg <= regWrData[CH_W-1:0];
      if (!strb.busy || strb.doneTick) chanActive <= chanNext;
      if (wrCtrl) begin
        enable  <= regWrData[BIT_EN];
        freeRun <= regWrData[BIT_FREE];
        irqEn   <= regWrData[BIT_IE];
        extMode <= regWrData[BIT_EXT];
      end
      if (strb.doneTick) begin
        doneFlag  <= 1'b1;
        resultReg <= resultIn;
      end else if (wrCtrl && regWrData[BIT_FLAG]) begin
        doneFlag <= 1'b0;
      end
    end
  end

  assign cfg.enable  = enable;
  assign cfg.freeRun = freeRun;
  assign cfg.irqEn   = irqEn;
  assign cfg.extMode = wrCtrl ? regWrData[BIT_EXT] : extMode;

  always_comb begin
    ctrlView           = '0;
    ctrlView[BIT_EN]   = enable;
    ctrlView[BIT_GO]   = strb.busy;
    ctrlView[BIT_FREE] = freeRun;
    ctrlView[BIT_IE]   = irqEn;
    ctrlView[BIT_FLAG] = doneFlag;
    ctrlView[BIT_EXT]  = extMode;
  end

  always_comb begin
    case (regAddr)
      A_CHAN:  regRdData = REG_W'(chanReg);
      A_CTRL:  regRdData = ctrlView;
      A_RESL:  regRdData = REG_W'(resultReg);
      default: regRdData = REG_W'(resultReg >> REG_W);
    endcase
  end

  assign chanSel      = chanActive;
  assign sampleStrobe = strb.sampleTick;
  assign irqOut       = doneFlag && irqEn;

  // R3: the mux channel holds while a conversion is under way
  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.doneTick) |=> $stable(chanActive));

  // R6: completion raises the flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneTick |=> doneFlag);

  // R6: completion captures the converter result
  p_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneTick |=> (resultReg == $past(resultIn)));

  // R7: the flag only falls through a write-one clear
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(wrCtrl && regWrData[BIT_FLAG]));

endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int CH_W        = 3,
  parameter int RES_W       = 10,
  parameter int REG_W       = 8,
  parameter int SAMPLE_TICK = 14,
  parameter int LEN_NORMAL  = 26,
  parameter int LEN_EXT     = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             idleEntry,
  input  logic             adcTick,
  input  logic [RES_W-1:0] resultIn,
  output logic [CH_W-1:0]  chanSel,
  output logic             sampleStrobe,
  output logic             irqOut
);

  seqStrobes_t strb;
  seqCfg_t     cfg;
  logic        swStartReq;

  adcSeqCtrl #(
    .SAMPLE_TICK(SAMPLE_TICK),
    .LEN_NORMAL (LEN_NORMAL),
    .LEN_EXT    (LEN_EXT)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .adcTick   (adcTick),
    .idleEntry (idleEntry),
    .swStartReq(swStartReq),
    .cfg       (cfg),
    .strb      (strb)
  );

  adcSeqRegs #(
    .CH_W (CH_W),
    .RES_W(RES_W),
    .REG_W(REG_W)
  ) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .resultIn    (resultIn),
    .strb        (strb),
    .cfg         (cfg),
    .swStartReq  (swStartReq),
    .chanSel     (chanSel),
    .sampleStrobe(sampleStrobe),
    .irqOut      (irqOut)
  );

endmodule

// File: tb/sim_adcSeqTop.sv
`timescale 1ns/1ps
module sim_adcSeqTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       idleEntry = 1'b0;
  logic       adcTick = 1'b0;
  logic [9:0] resultIn = 10'd0;
  logic [2:0] chanSel;
  logic       sampleStrobe;
  logic       irqOut;

  always #4 clk = ~clk;

  adcSeqTop u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .idleEntry(idleEntry),
    .adcTick(adcTick), .resultIn(resultIn), .chanSel(chanSel),
    .sampleStrobe(sampleStrobe), .irqOut(irqOut)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R1";

  // stimulus driver state
  int         tickMode = 0;
  logic [7:0] lfsr = 8'h5A;
  logic [1:0] rot = 2'd0;
  int         phaseCnt = 0;
  bit         wrPend = 0, idlePend = 0;
  logic [1:0] pAddr;
  logic [7:0] pData;

  // reference model state
  bit       mBusy, mConvExt, mEn, mFree, mIe, mExt, mFlag;
  int       mCnt;
  bit [2:0] mChanReg, mChanAct;
  bit [9:0] mRes;

  initial begin
    forever begin
      @(posedge clk); #1;
      phaseCnt++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (tickMode)
        0:       adcTick = 1'b1;
        1:       adcTick = (phaseCnt % 3 == 0);
        default: adcTick = lfsr[0] | lfsr[2];
      endcase
      resultIn = resultIn * 10'd3 + 10'd17;
      if (wrPend) begin
        regWrEn = 1'b1; regAddr = pAddr; regWrData = pData; wrPend = 0;
      end else begin
        regWrEn = 1'b0; rot = rot + 2'd1; regAddr = rot; regWrData = lfsr;
      end
      idleEntry = idlePend;
      idlePend  = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    pAddr = a; pData = d; wrPend = 1;
    cyc(1);
  endtask

  task automatic idlePulse();
    idlePend = 1;
    cyc(1);
  endtask

  // reference model: behavioural, updated on each clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mConvExt = 0; mEn = 0; mFree = 0; mIe = 0; mExt = 0;
      mFlag = 0; mCnt = 0; mChanReg = 0; mChanAct = 0; mRes = 0;
    end else begin
      bit wrC, wrK, done, start, extNext;
      bit [2:0] chNext;
      wrC     = regWrEn && regAddr == 2'd0;
      wrK     = regWrEn && regAddr == 2'd1;
      done    = mBusy && mEn && adcTick && (mCnt + 1 == (mConvExt ? 25 : 26));
      start   = !mBusy && ((wrK && regWrData[0] && regWrData[1]) ||
                (idleEntry && mEn && mIe && !mFree));
      extNext = wrK ? regWrData[5] : mExt;
      chNext  = wrC ? regWrData[2:0] : mChanReg;
      if (!mBusy || done) mChanAct = chNext;
      if (done) begin mFlag = 1; mRes = resultIn; end
      else if (wrK && regWrData[4]) mFlag = 0;
      if (start) begin mBusy = 1; mCnt = 0; mConvExt = extNext; end
      else if (!mEn) begin mBusy = 0; mCnt = 0; end
      else if (done) begin mBusy = mFree; mCnt = 0; mConvExt = extNext; end
      else if (mBusy && adcTick) mCnt++;
      if (wrC) mChanReg = regWrData[2:0];
      if (wrK) begin
        mEn = regWrData[0]; mFree = regWrData[2]; mIe = regWrData[3]; mExt = regWrData[5];
      end
    end
  end

  task automatic check(input string sig, input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL [%s] %s (%s) at %0t: got %0h expected %0h", phase, sig, req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int expRd, expSample;
    expSample = (mBusy && mEn && adcTick && mCnt == 13) ? 1 : 0;
    case (regAddr)
      2'd0:    expRd = mChanReg;                                   // R2 reserved bits zero
      2'd1:    expRd = {mExt, mFlag, mIe, mFree, mBusy, mEn};      // R4 R7 flag view
      2'd2:    expRd = mRes[7:0];                                  // R6 result low
      default: expRd = mRes[9:8];                                  // R6 result high
    endcase
    check("chanSel", "R3", chanSel, mChanAct);
    check("sampleStrobe", "R5", sampleStrobe, expSample);
    check("irqOut", "R8", irqOut, (mFlag && mIe) ? 1 : 0);
    check("regRdData", "R6", regRdData, expRd);
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL [%s] watchdog expired", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    phase = "R1";
    cyc(4);
    rstN = 1'b1;
    cyc(4);

    // R2: channel code and reserved bits
    phase = "R2";
    wrReg(2'd0, 8'hFD);
    cyc(3);
    wrReg(2'd0, 8'h05);
    cyc(3);

    // R4 R5 R6 R3: normal conversion, tick every cycle, channel change mid-way
    phase = "R4";
    tickMode = 0;
    wrReg(2'd1, 8'h03);
    cyc(5);
    phase = "R3";
    wrReg(2'd0, 8'h02);
    cyc(30);

    // R7: write-zero keeps flag, write-one clears it
    phase = "R7";
    wrReg(2'd1, 8'h01);
    cyc(3);
    wrReg(2'd1, 8'h11);
    cyc(3);

    // R6: extended mode, tick every third cycle, restart attempt while busy
    phase = "R6";
    tickMode = 1;
    wrReg(2'd1, 8'h23);
    cyc(20);
    phase = "R4";
    wrReg(2'd1, 8'h23);
    cyc(90);

    // R9 R8: idle-triggered start with interrupt, second idle pulse mid-way
    phase = "R9";
    tickMode = 0;
    wrReg(2'd1, 8'h39);
    cyc(2);
    idlePulse();
    cyc(10);
    phase = "R10";
    idlePulse();
    wrReg(2'd0, 8'h07);
    cyc(30);
    phase = "R8";
    wrReg(2'd1, 8'h19);
    cyc(3);

    // R10: idle ignored when not armed
    phase = "R10";
    wrReg(2'd1, 8'h01);
    idlePulse();
    cyc(35);
    wrReg(2'd1, 8'h08);
    idlePulse();
    cyc(35);

    // R11: free running, pseudo-random ticks
    phase = "R11";
    tickMode = 2;
    wrReg(2'd1, 8'h0F);
    cyc(4);
    idlePulse();
    cyc(60);
    wrReg(2'd0, 8'h03);
    cyc(150);
    wrReg(2'd1, 8'h19);
    cyc(80);

    // R12: abort by clearing enable
    phase = "R12";
    tickMode = 0;
    wrReg(2'd1, 8'h13);
    cyc(10);
    wrReg(2'd1, 8'h00);
    cyc(40);
    wrReg(2'd1, 8'h03);
    cyc(20);
    wrReg(2'd1, 8'h02);
    cyc(40);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule